// File: doc/BRIEF.md
# Shared Register Tag-Word Controller

This block owns the tag word of a register file that serves two uses at once: a floating-point register stack and a packed-integer register file mapped onto the same storage. Each register has a two-bit tag field. The value 11 means the register is empty and 00 means it holds valid data. Software ends a packed-integer routine with an empty-state instruction, which marks every register free for floating-point use. Any other packed-integer instruction claims the whole file by marking every register valid.

Each instruction is presented for one cycle on a strobe, together with its class. Before the tag word may change, the block checks two control-register bits and a pending floating-point fault flag. At most one fault is reported, chosen by a fixed priority. A faulting instruction leaves the tag word as it was. The outcome of the instruction appears on the registered outputs one clock after the strobe.

Top module: `regtag_ctrl`

## Requirements
- R1: After reset, `tag_word` is 0xFFFF (every register empty) and `fault_vec` is 000.
- R2: An accepted empty-state instruction (`op_valid`=1, `op_empty`=1, no fault) makes `tag_word` 0xFFFF on the next cycle.
- R3: An accepted instruction of any other packed class (`op_valid`=1, `op_empty`=0, no fault) makes `tag_word` 0x0000 on the next cycle.
- R4: When `op_valid`=1 and `ctl_emulate`=1, `fault_vec` is 001 (bit 0, invalid opcode) on the next cycle, whatever the other condition inputs are.
- R5: When `op_valid`=1, `ctl_emulate`=0 and `ctl_switched`=1, `fault_vec` is 010 (bit 1, device not available) on the next cycle, whatever the pending flag is.
- R6: When `op_valid`=1, both control bits are 0 and `fpu_fault_pending`=1, `fault_vec` is 100 (bit 2, floating-point error) on the next cycle.
- R7: An instruction that reports any fault leaves `tag_word` unchanged.
- R8: While `op_valid`=0, the class and condition inputs have no effect: `tag_word` holds its value and `fault_vec` reads 000 on the next cycle.
- R9: `fault_vec` never has more than one bit set, and it reads 000 after an accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Strobe: one packed instruction is presented this cycle |
| op_empty | input | 1 | 1 = empty-state instruction, 0 = any other packed instruction |
| ctl_emulate | input | 1 | Emulation control bit |
| ctl_switched | input | 1 | Task-switched control bit |
| fpu_fault_pending | input | 1 | An unmasked floating-point fault is pending |
| tag_word | output | 16 | Tag word: two bits per register, 11 = empty, 00 = valid |
| fault_vec | output | 3 | One-hot fault report for the previous strobe: bit0 invalid opcode, bit1 device not available, bit2 FP error |

## Verification
The bench builds the block with its default parameters: eight registers with a two-bit tag each, which gives the full 16-bit word. With this setting, every flip between the all-empty and all-valid patterns can be seen at the port. The condition inputs are drawn at random with a skew towards the quiet case, so that accepted and faulting instructions interleave. Directed steps cover each pair of priority conflicts, and an idle strobe is driven with every condition input asserted.

// File: rtl/regtag_pkg.sv
package regtag_pkg;
    localparam int FAULT_N         = 3;
    localparam int FAULT_BADOP_IDX = 0;
    localparam int FAULT_NODEV_IDX = 1;
    localparam int FAULT_FPERR_IDX = 2;
    typedef logic [FAULT_N-1:0] fault_vec_t;
endpackage

// File: rtl/regtag_fault_arb.sv
module regtag_fault_arb
    import regtag_pkg::*;
(
    input  logic       req,
    input  logic       emulate,
    input  logic       switched,
    input  logic       fp_pending,
    output fault_vec_t fault
);
    always_comb begin
        fault = '0;
        if (req) begin
            if (emulate)
                fault[FAULT_BADOP_IDX] = 1'b1;
            else if (switched)
                fault[FAULT_NODEV_IDX] = 1'b1;
            else if (fp_pending)
                fault[FAULT_FPERR_IDX] = 1'b1;
        end
    end
endmodule

// File: rtl/regtag_update.sv
module regtag_update #(
    parameter int NUM_REGS = 8,
    parameter int TAG_BITS = 2,
    localparam int TAG_W   = NUM_REGS * TAG_BITS
) (
    input  logic [TAG_W-1:0] cur_tag,
    input  logic             apply,
    input  logic             mark_empty,
    output logic [TAG_W-1:0] nxt_tag
);
    localparam logic [TAG_BITS-1:0] FIELD_EMPTY = '1;
    localparam logic [TAG_BITS-1:0] FIELD_VALID = '0;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_field
        always_comb begin
            if (!apply)
                nxt_tag[g*TAG_BITS +: TAG_BITS] = cur_tag[g*TAG_BITS +: TAG_BITS];
            else if (mark_empty)
                nxt_tag[g*TAG_BITS +: TAG_BITS] = FIELD_EMPTY;
            else
                nxt_tag[g*TAG_BITS +: TAG_BITS] = FIELD_VALID;
        end
    end
endmodule

// File: rtl/regtag_ctrl.sv
module regtag_ctrl
    import regtag_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int TAG_BITS = 2,
    localparam int TAG_W   = NUM_REGS * TAG_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic             op_empty,
    input  logic             ctl_emulate,
    input  logic             ctl_switched,
    input  logic             fpu_fault_pending,
    output logic [TAG_W-1:0] tag_word,
    output logic [FAULT_N-1:0] fault_vec
);
    typedef struct packed {
        logic [TAG_W-1:0] tag;
        fault_vec_t       fault;
    } state_t;

    state_t           st_d, st_q;
    fault_vec_t       fault_d;
    logic [TAG_W-1:0] tag_d;
    logic             accept_d;

    regtag_fault_arb u_arb (
        .req        (op_valid),
        .emulate    (ctl_emulate),
        .switched   (ctl_switched),
        .fp_pending (fpu_fault_pending),
        .fault      (fault_d)
    );

    assign accept_d = op_valid && (fault_d == '0);

    regtag_update #(
        .NUM_REGS (NUM_REGS),
        .TAG_BITS (TAG_BITS)
    ) u_upd (
        .cur_tag    (st_q.tag),
        .apply      (accept_d),
        .mark_empty (op_empty),
        .nxt_tag    (tag_d)
    );

    always_comb begin
        st_d       = st_q;
        st_d.tag   = tag_d;
        st_d.fault = fault_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tag   <= '1;
            st_q.fault <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tag_word  = st_q.tag;
    assign fault_vec = st_q.fault;
endmodule

// File: rtl/regtag_ctrl_chk.sv
module regtag_ctrl_chk #(
    parameter int TAG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic             op_empty,
    input logic             ctl_emulate,
    input logic             ctl_switched,
    input logic             fpu_fault_pending,
    input logic [TAG_W-1:0] tag_word,
    input logic [2:0]       fault_vec
);
    a_r2_empty_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_empty && !ctl_emulate && !ctl_switched && !fpu_fault_pending
        |=> tag_word == '1);

    a_r3_claim_all_zero: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_empty && !ctl_emulate && !ctl_switched && !fpu_fault_pending
        |=> tag_word == '0);

    a_r4_badop_first: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && ctl_emulate |=> fault_vec == 3'b001);

    a_r5_nodev_second: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !ctl_emulate && ctl_switched |=> fault_vec == 3'b010);

    a_r6_fperr_third: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !ctl_emulate && !ctl_switched && fpu_fault_pending
        |=> fault_vec == 3'b100);

    a_r7_fault_keeps_tag: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (ctl_emulate || ctl_switched || fpu_fault_pending)
        |=> $stable(tag_word));

    a_r8_idle_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(tag_word) && fault_vec == 3'b000);

    a_r9_single_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fault_vec));
endmodule

bind regtag_ctrl regtag_ctrl_chk #(.TAG_W(TAG_W)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .op_valid          (op_valid),
    .op_empty          (op_empty),
    .ctl_emulate       (ctl_emulate),
    .ctl_switched      (ctl_switched),
    .fpu_fault_pending (fpu_fault_pending),
    .tag_word          (tag_word),
    .fault_vec         (fault_vec)
);

// File: tb/regtag_ctrl_bench.sv
module regtag_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_empty = 1'b0;
    logic        ctl_emulate = 1'b0;
    logic        ctl_switched = 1'b0;
    logic        fpu_fault_pending = 1'b0;
    logic [15:0] tag_word;
    logic [2:0]  fault_vec;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] exp_tag = 16'hFFFF;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    regtag_ctrl u_regtag_ctrl (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_empty(op_empty),
        .ctl_emulate(ctl_emulate), .ctl_switched(ctl_switched),
        .fpu_fault_pending(fpu_fault_pending),
        .tag_word(tag_word), .fault_vec(fault_vec)
    );

    function automatic logic [2:0] model_fault(bit v, bit e, bit t, bit p);
        if (!v) return 3'b000;
        if (e)  return 3'b001;
        if (t)  return 3'b010;
        if (p)  return 3'b100;
        return 3'b000;
    endfunction

    function automatic string req_of(bit v, bit e, bit t, bit p);
        if (!v) return "R8";
        if (e)  return "R4";
        if (t)  return "R5";
        if (p)  return "R6";
        return "R9";
    endfunction

    task automatic check_tag(string r, logic [15:0] exp);
        n_cmp++;
        if (tag_word !== exp) begin
            n_bad++;
            $display("FAIL %s tag_word actual=%h expected=%h", r, tag_word, exp);
        end
    endtask

    task automatic check_fault(string r, logic [2:0] exp);
        n_cmp++;
        if (fault_vec !== exp) begin
            n_bad++;
            $display("FAIL %s fault_vec actual=%b expected=%b", r, fault_vec, exp);
        end
    endtask

    // drive at a falling edge, let one rising edge register it, check at the next falling edge
    task automatic step(bit v, bit m, bit e, bit t, bit p);
        logic [2:0] ef;
        string tr;
        op_valid = v; op_empty = m; ctl_emulate = e;
        ctl_switched = t; fpu_fault_pending = p;
        ef = model_fault(v, e, t, p);
        if (v && ef == 3'b000) begin
            exp_tag = m ? 16'hFFFF : 16'h0000;
            tr = m ? "R2" : "R3";
        end else begin
            tr = (v) ? "R7" : "R8";
        end
        @(negedge clk);
        check_fault(req_of(v, e, t, p), ef);
        check_tag(tr, exp_tag);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_tag("R1", 16'hFFFF);
        check_fault("R1", 3'b000);

        step(1, 0, 0, 0, 0);   // R3 claim
        step(1, 1, 1, 1, 1);   // R4 beats all, R7 tag kept at 0000
        step(1, 1, 0, 1, 1);   // R5 beats pending
        step(1, 1, 0, 0, 1);   // R6
        step(0, 1, 1, 1, 1);   // R8 idle with every input set
        step(1, 1, 0, 0, 0);   // R2 empty
        step(1, 0, 1, 0, 0);   // R4 alone, R7 tag kept at FFFF
        step(1, 0, 0, 1, 0);   // R5 alone
        step(0, 0, 0, 0, 0);   // R8 quiet idle

        for (int i = 0; i < 400; i++) begin
            bit v, m, e, t, p;
            v = ($urandom % 4) != 0;
            m = $urandom % 2;
            e = ($urandom % 6) == 0;
            t = ($urandom % 5) == 0;
            p = ($urandom % 4) == 0;
            step(v, m, e, t, p);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule